// File: doc/BRIEF.md
# Per-Cycle Hardware Thread Issue Selector

This block sits at the front of a single-issue pipeline that is shared by several hardware threads. Each clock cycle it decides which thread may issue. It presents that thread's number and its program counter, together with a valid flag. Because every thread keeps its own program counter inside the block, moving from one thread to another costs no cycle.

The pipeline feeds status back to the block. For each thread it reports whether the thread is active, whether it has a short stall, and whether it is waiting on a long-latency event such as a second-level cache miss. It also flags when the instruction just issued is a branch or a load, and it can redirect any thread's program counter.

Three scheduling policies can be selected:
- **Round-robin:** threads take turns cycle by cycle.
- **Preferred thread:** one nominated thread issues whenever it can, and the others fill only its empty slots.
- **Coarse:** the block stays on one thread and moves to another only when that thread reports a long-latency stall.

Top module: `thread_issue_sel`

## Requirements
- R1: After reset every thread's PC equals START_PC, no thread carries a branch/load penalty, and the first round-robin choice is thread 0.
- R2: The valid output is high only for a thread whose ready bit is 1, whose stall and long-stall bits are 0 and whose penalty has expired. The PC output is that thread's stored PC.
- R3: In round-robin mode (mode_i = 2'b00) the search starts at the thread after the last one issued and wraps from the highest thread number to 0. With all four threads eligible, the issue order is 0,1,2,3,0.
- R4: A stalled thread is skipped with no lost cycle. With thread 1 stalled, round-robin issues 0,2,3,0,2.
- R5: When no thread is eligible, the valid output is low and the last-issued thread is kept, so the search resumes after it.
- R6: When a thread issues with iss_pen_i = 1, it is excluded for the next 3 cycles and is eligible again on the 4th. Other threads fill those cycles.
- R7: Each issue advances the issuing thread's PC by 4. An update (upd_vld_i = 1) writes upd_pc_i into thread upd_tid_i, and it takes precedence over the advance when both hit the same thread in the same cycle.
- R8: In preferred mode (mode_i = 2'b01) the thread pref_tid_i issues every cycle it is eligible. Otherwise the other eligible threads are chosen round-robin, starting after the last issued thread.
- R9: In coarse mode (mode_i = 2'b10) the last issued thread keeps issuing while it is eligible. A short stall on it gives an empty cycle (valid low). If it reports a long stall or is not ready, the next eligible thread after it is chosen.
- R10: mode_i = 2'b11 behaves as round-robin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Policy: 00 round-robin, 01 preferred, 10 coarse, 11 round-robin |
| pref_tid_i | input | TW | Preferred thread number |
| ready_i | input | NUM_THR | Thread active |
| stall_i | input | NUM_THR | Short stall per thread |
| long_stall_i | input | NUM_THR | Long-latency stall per thread |
| iss_pen_i | input | 1 | The instruction issued this cycle is a branch or load |
| upd_vld_i | input | 1 | PC redirect strobe |
| upd_tid_i | input | TW | Thread to redirect |
| upd_pc_i | input | PC_W | New PC for the redirect |
| sel_vld_o | output | 1 | A thread issues this cycle |
| sel_tid_o | output | TW | Issuing thread number |
| sel_pc_o | output | PC_W | Issuing thread's PC |

## Verification
The scheduler is driven with several eligibility patterns, each aimed at a different failure:
- **All threads eligible:** exposes a wrong starting point or a wrong wrap in the rotation.
- **One thread short-stalled:** shows whether a skip wastes a slot.
- **Every thread blocked, then released:** shows whether the rotation pointer is disturbed by empty cycles.
- **Two threads with a branch penalty:** counts exactly how many cycles the penalised thread is kept out.
- **Preferred and coarse sequences:** these pair a short stall with a long stall, which distinguishes backfilling from holding a bubble and from switching.
- **Coinciding redirect and issue:** shows which of the two writes to the PC wins.

// File: rtl/thr_sel_pkg.sv
package thr_sel_pkg;
   typedef enum logic [1:0] {
      SEL_RR     = 2'b00,
      SEL_PREF   = 2'b01,
      SEL_COARSE = 2'b10,
      SEL_RSVD   = 2'b11
   } sel_mode_e;
endpackage

// File: rtl/thr_rr_pick.sv
// Rotating priority search: first set bit of elig_i at or after start_i.
module thr_rr_pick #(
   parameter int N  = 4,
   parameter int TW = 2
) (
   input  logic [N-1:0]  elig_i,
   input  logic [TW-1:0] start_i,
   output logic          found_o,
   output logic [TW-1:0] idx_o
);
   always_comb begin
      int j;
      found_o = 1'b0;
      idx_o   = '0;
      for (int k = 0; k < N; k++) begin
         j = (int'(start_i) + k) % N;
         if (!found_o && elig_i[j]) begin
            found_o = 1'b1;
            idx_o   = TW'(j);
         end
      end
   end
endmodule

// File: rtl/thr_pen_ctr.sv
// One countdown per thread; a thread is free when its count is zero.
module thr_pen_ctr #(
   parameter int N   = 4,
   parameter int PEN = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] load_i,
   output logic [N-1:0] free_o
);
   localparam int CW = $clog2(PEN + 1);

   for (genvar t = 0; t < N; t++) begin : g_thr
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n)               cnt_q <= '0;
         else if (load_i[t])       cnt_q <= CW'(PEN);
         else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
      end
      assign free_o[t] = (cnt_q == '0);
   end
endmodule

// File: rtl/thr_pc_file.sv
// Per-thread program counters; redirect beats sequential advance.
module thr_pc_file #(
   parameter int          N     = 4,
   parameter int          TW    = 2,
   parameter int          PC_W  = 32,
   parameter logic [PC_W-1:0] START = '0,
   parameter int          STEP  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            iss_vld_i,
   input  logic [TW-1:0]   iss_tid_i,
   input  logic            upd_vld_i,
   input  logic [TW-1:0]   upd_tid_i,
   input  logic [PC_W-1:0] upd_pc_i,
   input  logic [TW-1:0]   rd_tid_i,
   output logic [PC_W-1:0] rd_pc_o
);
   logic [PC_W-1:0] pc_q [N];

   for (genvar t = 0; t < N; t++) begin : g_pc
      always_ff @(posedge clk) begin
         if (!rst_n)
            pc_q[t] <= START;
         else if (upd_vld_i && upd_tid_i == TW'(t))
            pc_q[t] <= upd_pc_i;
         else if (iss_vld_i && iss_tid_i == TW'(t))
            pc_q[t] <= pc_q[t] + PC_W'(STEP);
      end
   end

   assign rd_pc_o = pc_q[rd_tid_i];
endmodule

// File: rtl/thread_issue_sel.sv
module thread_issue_sel
   import thr_sel_pkg::*;
#(
   parameter int              NUM_THR  = 4,
   parameter int              PC_W     = 32,
   parameter int              PEN_CYC  = 3,
   parameter int              PC_STEP  = 4,
   parameter logic [PC_W-1:0] START_PC = 32'h0000_1000,
   localparam int             TW       = $clog2(NUM_THR)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         mode_i,
   input  logic [TW-1:0]      pref_tid_i,
   input  logic [NUM_THR-1:0] ready_i,
   input  logic [NUM_THR-1:0] stall_i,
   input  logic [NUM_THR-1:0] long_stall_i,
   input  logic               iss_pen_i,
   input  logic               upd_vld_i,
   input  logic [TW-1:0]      upd_tid_i,
   input  logic [PC_W-1:0]    upd_pc_i,
   output logic               sel_vld_o,
   output logic [TW-1:0]      sel_tid_o,
   output logic [PC_W-1:0]    sel_pc_o
);
   if (NUM_THR < 2) begin : g_bad_thr
      $error("NUM_THR must be at least 2");
   end
   if ((1 << TW) != NUM_THR) begin : g_bad_pow
      $error("NUM_THR must be a power of two");
   end
   if (PEN_CYC < 1) begin : g_bad_pen
      $error("PEN_CYC must be at least 1");
   end
   if (PC_W < 8) begin : g_bad_pcw
      $error("PC_W must be at least 8");
   end

   logic [TW-1:0]      last_q;
   logic [TW-1:0]      nxt_start;
   logic [NUM_THR-1:0] thr_free;
   logic [NUM_THR-1:0] elig;
   logic [NUM_THR-1:0] pk_mask;
   logic [NUM_THR-1:0] pen_ld;
   logic               pk_found;
   logic [TW-1:0]      pk_idx;
   logic               take_dir;
   logic [TW-1:0]      dir_tid;
   logic               allow_pk;
   sel_mode_e          mode;

   assign mode      = sel_mode_e'(mode_i);
   assign elig      = ready_i & ~stall_i & ~long_stall_i & thr_free;
   assign nxt_start = (last_q == TW'(NUM_THR - 1)) ? '0 : last_q + 1'b1;

   always_comb begin
      pk_mask  = elig;
      take_dir = 1'b0;
      dir_tid  = last_q;
      allow_pk = 1'b1;
      unique case (mode)
         SEL_PREF: begin
            dir_tid = pref_tid_i;
            if (elig[pref_tid_i]) take_dir = 1'b1;
            pk_mask = elig & ~(NUM_THR'(1) << pref_tid_i);
         end
         SEL_COARSE: begin
            if (elig[last_q]) take_dir = 1'b1;
            else if (!(long_stall_i[last_q] || !ready_i[last_q])) allow_pk = 1'b0;
            pk_mask = elig & ~(NUM_THR'(1) << last_q);
         end
         default: ;
      endcase
   end

   thr_rr_pick #(.N(NUM_THR), .TW(TW)) u_pick (
      .elig_i  (pk_mask),
      .start_i (nxt_start),
      .found_o (pk_found),
      .idx_o   (pk_idx)
   );

   assign sel_vld_o = take_dir | (allow_pk & pk_found);
   assign sel_tid_o = take_dir ? dir_tid : pk_idx;

   always_comb begin
      for (int t = 0; t < NUM_THR; t++)
         pen_ld[t] = sel_vld_o & iss_pen_i & (sel_tid_o == TW'(t));
   end

   thr_pen_ctr #(.N(NUM_THR), .PEN(PEN_CYC)) u_pen (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (pen_ld),
      .free_o (thr_free)
   );

   thr_pc_file #(
      .N(NUM_THR), .TW(TW), .PC_W(PC_W), .START(START_PC), .STEP(PC_STEP)
   ) u_pcs (
      .clk       (clk),
      .rst_n     (rst_n),
      .iss_vld_i (sel_vld_o),
      .iss_tid_i (sel_tid_o),
      .upd_vld_i (upd_vld_i),
      .upd_tid_i (upd_tid_i),
      .upd_pc_i  (upd_pc_i),
      .rd_tid_i  (sel_tid_o),
      .rd_pc_o   (sel_pc_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)         last_q <= TW'(NUM_THR - 1);
      else if (sel_vld_o) last_q <= sel_tid_o;
   end
endmodule

// File: rtl/thread_issue_sel_chk.sv
module thread_issue_sel_chk
   import thr_sel_pkg::*;
#(
   parameter int NUM_THR = 4,
   localparam int TW     = $clog2(NUM_THR)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [1:0]         mode_i,
   input logic [TW-1:0]      pref_tid_i,
   input logic [NUM_THR-1:0] ready_i,
   input logic [NUM_THR-1:0] stall_i,
   input logic [NUM_THR-1:0] long_stall_i,
   input logic               iss_pen_i,
   input logic               sel_vld_o,
   input logic [TW-1:0]      sel_tid_o,
   input logic [NUM_THR-1:0] thr_free
);
   logic               run_q;
   logic [NUM_THR-1:0] can_go;

   assign can_go = ready_i & ~stall_i & ~long_stall_i & thr_free;

   always_ff @(posedge clk) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= 1'b1;
   end

   // R2
   elig_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_vld_o |-> can_go[sel_tid_o]);

   // R6
   pen_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && sel_vld_o && iss_pen_i) |=> !(sel_vld_o && sel_tid_o == $past(sel_tid_o)));

   // R5
   no_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_vld_o && mode_i != SEL_COARSE) |-> (can_go == '0));

   // R8
   pref_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == SEL_PREF && can_go[pref_tid_i]) |-> (sel_vld_o && sel_tid_o == pref_tid_i));

   // R9
   coarse_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && mode_i == SEL_COARSE && $past(mode_i) == SEL_COARSE && $past(sel_vld_o)
       && sel_vld_o && sel_tid_o != $past(sel_tid_o))
      |-> (long_stall_i[$past(sel_tid_o)] || !ready_i[$past(sel_tid_o)]));
endmodule

bind thread_issue_sel thread_issue_sel_chk #(.NUM_THR(NUM_THR)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mode_i       (mode_i),
   .pref_tid_i   (pref_tid_i),
   .ready_i      (ready_i),
   .stall_i      (stall_i),
   .long_stall_i (long_stall_i),
   .iss_pen_i    (iss_pen_i),
   .sel_vld_o    (sel_vld_o),
   .sel_tid_o    (sel_tid_o),
   .thr_free     (thr_free)
);

// File: tb/sim_thread_issue_sel.sv
`timescale 1ns/1ps
module sim_thread_issue_sel;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  mode_i;
   logic [1:0]  pref_tid_i;
   logic [3:0]  ready_i, stall_i, long_stall_i;
   logic        iss_pen_i, upd_vld_i;
   logic [1:0]  upd_tid_i;
   logic [31:0] upd_pc_i;
   logic        sel_vld_o;
   logic [1:0]  sel_tid_o;
   logic [31:0] sel_pc_o;

   int n_chk  = 0;
   int n_fail = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   thread_issue_sel u0 (.*);

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got running exp finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
         end
      end
   end

   task automatic chk(input bit ev, input int et, input logic [31:0] ep, input string tag);
      n_chk++;
      if (sel_vld_o !== ev || (ev && (sel_tid_o !== 2'(et) || sel_pc_o !== ep))) begin
         n_fail++;
         $display("FAIL %s: got vld=%0b tid=%0d pc=%h exp vld=%0b tid=%0d pc=%h",
                  tag, sel_vld_o, sel_tid_o, sel_pc_o, ev, et, ep);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic do_reset(input logic [1:0] m);
      @(negedge clk);
      rst_n = 1'b0; mode_i = m; pref_tid_i = 2'd0;
      ready_i = 4'hF; stall_i = 4'h0; long_stall_i = 4'h0;
      iss_pen_i = 1'b0; upd_vld_i = 1'b0; upd_tid_i = 2'd0; upd_pc_i = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_rr();
      do_reset(2'b00);
      #1 chk(1, 0, 32'h1000, "R1 reset first pick");
      tick(); #1 chk(1, 1, 32'h1000, "R3 rr order");
      tick(); #1 chk(1, 2, 32'h1000, "R3 rr order");
      tick(); #1 chk(1, 3, 32'h1000, "R1 R3 rr order untouched pc");
      tick(); #1 chk(1, 0, 32'h1004, "R3 R7 wrap and advance");
   endtask

   task automatic t_skip();
      do_reset(2'b00);
      stall_i = 4'b0010;
      #1 chk(1, 0, 32'h1000, "R4 skip");
      tick(); #1 chk(1, 2, 32'h1000, "R4 skip stalled 1");
      tick(); #1 chk(1, 3, 32'h1000, "R4 skip");
      tick(); #1 chk(1, 0, 32'h1004, "R4 skip wrap");
      tick(); #1 chk(1, 2, 32'h1004, "R4 R2 skip again");
   endtask

   task automatic t_none();
      do_reset(2'b00);
      #1 chk(1, 0, 32'h1000, "R5 prelude");
      tick(); stall_i = 4'hF;
      #1 chk(0, 0, 32'h0, "R5 none eligible");
      tick(); ready_i = 4'h0; stall_i = 4'h0;
      #1 chk(0, 0, 32'h0, "R5 R2 none ready");
      tick(); ready_i = 4'hF;
      #1 chk(1, 1, 32'h1000, "R5 resume after last");
   endtask

   task automatic t_pen();
      do_reset(2'b00);
      ready_i = 4'b0011; iss_pen_i = 1'b1;
      #1 chk(1, 0, 32'h1000, "R6 branch issue");
      tick(); iss_pen_i = 1'b0;
      #1 chk(1, 1, 32'h1000, "R6 penalty cycle 1");
      tick(); #1 chk(1, 1, 32'h1004, "R6 penalty cycle 2");
      tick(); #1 chk(1, 1, 32'h1008, "R6 penalty cycle 3");
      tick(); #1 chk(1, 0, 32'h1004, "R6 eligible again");
   endtask

   task automatic t_pc();
      do_reset(2'b00);
      ready_i = 4'b0001; upd_vld_i = 1'b1; upd_tid_i = 2'd0; upd_pc_i = 32'h2000;
      #1 chk(1, 0, 32'h1000, "R7 redirect same cycle");
      tick(); upd_vld_i = 1'b0;
      #1 chk(1, 0, 32'h2000, "R7 redirect wins");
      tick(); upd_vld_i = 1'b1; upd_tid_i = 2'd2; upd_pc_i = 32'h3000;
      #1 chk(1, 0, 32'h2004, "R7 advance");
      tick(); upd_vld_i = 1'b0; ready_i = 4'b0100;
      #1 chk(1, 2, 32'h3000, "R7 redirect other thread");
   endtask

   task automatic t_pref();
      do_reset(2'b01);
      pref_tid_i = 2'd2;
      #1 chk(1, 2, 32'h1000, "R8 preferred");
      tick(); #1 chk(1, 2, 32'h1004, "R8 preferred again");
      tick(); stall_i = 4'b0100;
      #1 chk(1, 3, 32'h1000, "R8 backfill");
      tick(); #1 chk(1, 0, 32'h1000, "R8 backfill rotate");
      tick(); stall_i = 4'b0000;
      #1 chk(1, 2, 32'h1008, "R8 preferred returns");
   endtask

   task automatic t_coarse();
      do_reset(2'b10);
      #1 chk(1, 3, 32'h1000, "R9 coarse start");
      tick(); #1 chk(1, 3, 32'h1004, "R9 coarse hold");
      tick(); stall_i = 4'b1000;
      #1 chk(0, 0, 32'h0, "R9 short stall bubble");
      tick(); stall_i = 4'b0000; long_stall_i = 4'b1000;
      #1 chk(1, 0, 32'h1000, "R9 long stall switch");
      tick(); #1 chk(1, 0, 32'h1004, "R9 stay on new thread");
   endtask

   task automatic t_rsvd();
      do_reset(2'b11);
      #1 chk(1, 0, 32'h1000, "R10 reserved mode");
      tick(); #1 chk(1, 1, 32'h1000, "R10 reserved rotates");
   endtask

   initial begin
      rst_n = 1'b0;
      t_rr();
      t_skip();
      t_none();
      t_pen();
      t_pc();
      t_pref();
      t_coarse();
      t_rsvd();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule